// File: doc/BRIEF.md
# Audio Ring-Buffer DMA Channel

This block moves audio samples between system memory and the two FIFO sides of one audio unit. The playback direction fetches 32-bit words from a memory buffer and hands them to the transmit FIFO. The record direction takes words from the receive FIFO and stores them into a second memory buffer. Software programs a base address and a byte length for each direction, then starts either direction through one shared control register. Each direction raises one interrupt pulse when half its buffer has moved and another when all of it has moved. When its reload flag is set, the direction returns to its base address and keeps going with no software action, so the buffer behaves as a two-half ring.

All data interfaces are valid/ready. A word moves only on a cycle where valid and ready are both high. Once the engine raises a valid (memory read request, transmit word, memory write), it keeps the valid high and the payload unchanged until it is accepted. The single exception is a stop, which withdraws the valid at once. The engine waits in the matching state for as long as the far side holds ready low, so any amount of back-pressure is absorbed without loss. One read request is outstanding at a time. A read response is accepted only while the playback side is waiting for it; a response that arrives after a stop is dropped. A start is refused when the programmed length is below 8 bytes.

Top module: `audma_ring`

## Requirements
- R1: After reset every register reads 0, all valid and ready outputs toward memory and the FIFOs are low, and no interrupt pulse is raised.
- R2: Byte offsets 0x00/0x04 hold the playback/record base address and 0x08/0x0C the playback/record length. Bits 1:0 of each always read 0, and each length keeps only bits 25:2, so it reads as a multiple of 4 no larger than 0x03FFFFFC.
- R3: In the control register at 0x10, the playback fields are enable bit 0, stop bit 1, reload bit 2 and alignment code bits 9:8. The record fields are the same, shifted up by 16 (bits 16, 17, 18 and 25:24). Reload and alignment codes read back as written. Stop bits always read 0. An enable bit reads 1 exactly while its direction is running.
- R4: Playback reads memory at base, base+4, base+8, … and delivers each returned word, in order and unaltered, on the transmit stream under any back-pressure.
- R5: Record writes the n-th received word (n from 0) to base+4n, in order and unaltered, under any back-pressure.
- R6: The current-count registers (0x14 playback, 0x18 record) load the programmed length at start and drop by 4 for each word completed.
- R7: A half interrupt pulses for one cycle, in the cycle after the word that takes the remaining count from above half the length to at most half.
- R8: A full interrupt pulses for one cycle after the word that brings the remaining count to 0. Without reload, that direction then clears its enable and issues nothing more.
- R9: With reload set, reaching a count of 0 restarts the direction at its base address with the full length, with no pause for software.
- R10: Writing 1 to a direction's stop bit, or writing 0 to its enable bit while it is running, halts that direction at once. Its enable then reads 0 and its current count keeps its value.
- R11: A start, stop or completion on one direction leaves the other direction's enable, count and data flow unchanged.
- R12: Writing enable 1 to a direction that is already running neither restarts it nor reloads its count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | REG_AW | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr (combinational) |
| rd_req_valid | output | 1 | Playback memory read request valid |
| rd_req_ready | input | 1 | Memory accepts the read request |
| rd_req_addr | output | ADDR_W | Read address |
| rd_rsp_valid | input | 1 | Read data returned |
| rd_rsp_ready | output | 1 | Engine is waiting for read data |
| rd_rsp_data | input | DATA_W | Read data |
| tx_valid | output | 1 | Word offered to the transmit FIFO |
| tx_ready | input | 1 | Transmit FIFO accepts the word |
| tx_data | output | DATA_W | Transmit word |
| rx_valid | input | 1 | Receive FIFO offers a word |
| rx_ready | output | 1 | Engine accepts the received word |
| rx_data | input | DATA_W | Received word |
| wr_valid | output | 1 | Record memory write valid |
| wr_ready | input | 1 | Memory accepts the write |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | DATA_W | Write data |
| tx_half_irq | output | 1 | Playback half-buffer pulse |
| tx_full_irq | output | 1 | Playback full-buffer pulse |
| rx_half_irq | output | 1 | Record half-buffer pulse |
| rx_full_irq | output | 1 | Record full-buffer pulse |

## Verification
The bench builds the block with its default parameters: 32-bit addresses and data, a 26-bit length field and a 5-bit register offset. The lengths it programs are small, 8 to 32 bytes. With lengths that short, two or three reload wraps, the minimum-size transfer and half marks that land on the first word all happen within a few hundred cycles. Meanwhile, the full-width length register is still exercised for its masking.

// File: rtl/audma_pkg.sv
package audma_pkg;
  localparam int REG_W        = 32;
  localparam int NDIR         = 2;
  localparam int DIR_TX       = 0;
  localparam int DIR_RX       = 1;
  localparam int WORD_BYTES   = 4;
  localparam int MIN_BYTES    = 8;

  // register byte offsets; per-direction registers sit 4 bytes apart
  localparam int OFS_BASE     = 'h00;
  localparam int OFS_LEN      = 'h08;
  localparam int OFS_CTRL     = 'h10;
  localparam int OFS_CUR      = 'h14;

  // control field positions relative to a direction's half of the word
  localparam int CTL_SPAN     = 16;
  localparam int CTL_EN       = 0;
  localparam int CTL_STOP     = 1;
  localparam int CTL_RELOAD   = 2;
  localparam int CTL_ALIGN_LO = 8;

  typedef enum logic [1:0] {
    ALIGN_NONE  = 2'd0,
    ALIGN_BYTE4 = 2'd1,
    ALIGN_WORD2 = 2'd2
  } align_e;

  typedef enum logic [1:0] {
    PLAY_REQ  = 2'd0,
    PLAY_RSP  = 2'd1,
    PLAY_PUSH = 2'd2
  } play_st_e;

  typedef enum logic {
    REC_GET = 1'b0,
    REC_PUT = 1'b1
  } rec_st_e;
endpackage

// File: rtl/audma_seq.sv
module audma_seq
  import audma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              step_i,
  input  logic              reload_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [CNT_W-1:0]  len_i,
  output logic              active_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  remain_o,
  output logic              half_o,
  output logic              full_o
);
  localparam logic [CNT_W-1:0]  CNT_STEP  = CNT_W'(WORD_BYTES);
  localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(WORD_BYTES);

  logic [CNT_W-1:0] remain_nxt;
  logic [CNT_W-1:0] half_mark;
  logic             cross_half;

  assign remain_nxt = remain_o - CNT_STEP;
  assign half_mark  = len_i >> 1;
  assign cross_half = (remain_o > half_mark) && (remain_nxt <= half_mark);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_o <= 1'b0;
      addr_o   <= '0;
      remain_o <= '0;
      half_o   <= 1'b0;
      full_o   <= 1'b0;
    end else begin
      half_o <= 1'b0;
      full_o <= 1'b0;
      if (stop_i) begin
        active_o <= 1'b0;
      end else if (start_i) begin
        active_o <= 1'b1;
        addr_o   <= base_i;
        remain_o <= len_i;
      end else if (active_o && step_i) begin
        half_o <= cross_half;
        if (remain_nxt == '0) begin
          full_o <= 1'b1;
          if (reload_i) begin
            addr_o   <= base_i;
            remain_o <= len_i;
          end else begin
            active_o <= 1'b0;
            remain_o <= '0;
          end
        end else begin
          addr_o   <= addr_o + ADDR_STEP;
          remain_o <= remain_nxt;
        end
      end
    end
  end
endmodule

// File: rtl/audma_play.sv
module audma_play
  import audma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active_i,
  input  logic              flush_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  output logic              rd_rsp_ready,
  input  logic [DATA_W-1:0] rd_rsp_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  output logic              step_o
);
  play_st_e          st_q;
  logic [DATA_W-1:0] word_q;

  assign rd_req_valid = active_i && (st_q == PLAY_REQ);
  assign rd_req_addr  = addr_i;
  assign rd_rsp_ready = active_i && (st_q == PLAY_RSP);
  assign tx_valid     = active_i && (st_q == PLAY_PUSH);
  assign tx_data      = word_q;
  assign step_o       = tx_valid && tx_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= PLAY_REQ;
      word_q <= '0;
    end else if (flush_i || !active_i) begin
      st_q <= PLAY_REQ;
    end else begin
      unique case (st_q)
        PLAY_REQ:  if (rd_req_ready) st_q <= PLAY_RSP;
        PLAY_RSP:  if (rd_rsp_valid) begin
                     word_q <= rd_rsp_data;
                     st_q   <= PLAY_PUSH;
                   end
        PLAY_PUSH: if (tx_ready) st_q <= PLAY_REQ;
        default:   st_q <= PLAY_REQ;
      endcase
    end
  end
endmodule

// File: rtl/audma_rec.sv
module audma_rec
  import audma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active_i,
  input  logic              flush_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              step_o
);
  rec_st_e           st_q;
  logic [DATA_W-1:0] word_q;

  assign rx_ready = active_i && (st_q == REC_GET);
  assign wr_valid = active_i && (st_q == REC_PUT);
  assign wr_addr  = addr_i;
  assign wr_data  = word_q;
  assign step_o   = wr_valid && wr_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= REC_GET;
      word_q <= '0;
    end else if (flush_i || !active_i) begin
      st_q <= REC_GET;
    end else begin
      unique case (st_q)
        REC_GET: if (rx_valid) begin
                   word_q <= rx_data;
                   st_q   <= REC_PUT;
                 end
        REC_PUT: if (wr_ready) st_q <= REC_GET;
        default: st_q <= REC_GET;
      endcase
    end
  end
endmodule

// File: rtl/audma_ring.sv
module audma_ring
  import audma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 26,
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [REG_AW-1:0] cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  output logic              rd_rsp_ready,
  input  logic [DATA_W-1:0] rd_rsp_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              tx_half_irq,
  output logic              tx_full_irq,
  output logic              rx_half_irq,
  output logic              rx_full_irq
);
  localparam logic [REG_AW-1:0] A_CTRL = REG_AW'(OFS_CTRL);

  logic                  ctrl_wr;
  logic [NDIR-1:0]       start_cmd;
  logic [NDIR-1:0]       stop_cmd;
  logic [NDIR-1:0]       active;
  logic [NDIR-1:0]       reload_q;
  logic [NDIR-1:0]       step;
  logic [NDIR-1:0]       half_p;
  logic [NDIR-1:0]       full_p;
  logic [ADDR_W-1:0]     base_q   [NDIR];
  logic [CNT_W-1:0]      len_q    [NDIR];
  logic [1:0]            align_q  [NDIR];
  logic [ADDR_W-1:0]     cur_addr [NDIR];
  logic [CNT_W-1:0]      remain   [NDIR];
  logic [REG_W-1:0]      ctrl_rd;

  assign ctrl_wr = cfg_we && (cfg_addr == A_CTRL);

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    localparam int BO = d * CTL_SPAN;
    localparam logic [REG_AW-1:0] A_BASE = REG_AW'(OFS_BASE + WORD_BYTES * d);
    localparam logic [REG_AW-1:0] A_LEN  = REG_AW'(OFS_LEN + WORD_BYTES * d);

    logic [ADDR_W-1:0] base_r;
    logic [CNT_W-1:0]  len_r;
    logic              reload_r;
    logic [1:0]        align_r;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_r   <= '0;
        len_r    <= '0;
        reload_r <= 1'b0;
        align_r  <= ALIGN_NONE;
      end else begin
        if (cfg_we && (cfg_addr == A_BASE))
          base_r <= {cfg_wdata[ADDR_W-1:2], 2'b00};
        if (cfg_we && (cfg_addr == A_LEN))
          len_r <= {cfg_wdata[CNT_W-1:2], 2'b00};
        if (ctrl_wr) begin
          reload_r <= cfg_wdata[BO+CTL_RELOAD];
          align_r  <= cfg_wdata[BO+CTL_ALIGN_LO +: 2];
        end
      end
    end

    assign stop_cmd[d]  = ctrl_wr && (cfg_wdata[BO+CTL_STOP] ||
                                      (!cfg_wdata[BO+CTL_EN] && active[d]));
    assign start_cmd[d] = ctrl_wr && !cfg_wdata[BO+CTL_STOP] && cfg_wdata[BO+CTL_EN] &&
                          !active[d] && (len_r >= CNT_W'(MIN_BYTES));

    assign base_q[d]   = base_r;
    assign len_q[d]    = len_r;
    assign reload_q[d] = reload_r;
    assign align_q[d]  = align_r;

    audma_seq #(
      .ADDR_W (ADDR_W),
      .CNT_W  (CNT_W)
    ) seq_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_cmd[d]),
      .stop_i   (stop_cmd[d]),
      .step_i   (step[d]),
      .reload_i (reload_r),
      .base_i   (base_r),
      .len_i    (len_r),
      .active_o (active[d]),
      .addr_o   (cur_addr[d]),
      .remain_o (remain[d]),
      .half_o   (half_p[d]),
      .full_o   (full_p[d])
    );
  end

  audma_play #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) play_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .active_i     (active[DIR_TX]),
    .flush_i      (stop_cmd[DIR_TX]),
    .addr_i       (cur_addr[DIR_TX]),
    .rd_req_valid (rd_req_valid),
    .rd_req_ready (rd_req_ready),
    .rd_req_addr  (rd_req_addr),
    .rd_rsp_valid (rd_rsp_valid),
    .rd_rsp_ready (rd_rsp_ready),
    .rd_rsp_data  (rd_rsp_data),
    .tx_valid     (tx_valid),
    .tx_ready     (tx_ready),
    .tx_data      (tx_data),
    .step_o       (step[DIR_TX])
  );

  audma_rec #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) rec_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .active_i (active[DIR_RX]),
    .flush_i  (stop_cmd[DIR_RX]),
    .addr_i   (cur_addr[DIR_RX]),
    .rx_valid (rx_valid),
    .rx_ready (rx_ready),
    .rx_data  (rx_data),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .step_o   (step[DIR_RX])
  );

  assign tx_half_irq = half_p[DIR_TX];
  assign tx_full_irq = full_p[DIR_TX];
  assign rx_half_irq = half_p[DIR_RX];
  assign rx_full_irq = full_p[DIR_RX];

  always_comb begin
    ctrl_rd = '0;
    for (int d = 0; d < NDIR; d++) begin
      ctrl_rd[d*CTL_SPAN+CTL_EN]            = active[d];
      ctrl_rd[d*CTL_SPAN+CTL_RELOAD]        = reload_q[d];
      ctrl_rd[d*CTL_SPAN+CTL_ALIGN_LO +: 2] = align_q[d];
    end
  end

  always_comb begin
    cfg_rdata = '0;
    unique case (cfg_addr)
      REG_AW'(OFS_BASE):              cfg_rdata = REG_W'(base_q[DIR_TX]);
      REG_AW'(OFS_BASE + WORD_BYTES): cfg_rdata = REG_W'(base_q[DIR_RX]);
      REG_AW'(OFS_LEN):               cfg_rdata = REG_W'(len_q[DIR_TX]);
      REG_AW'(OFS_LEN + WORD_BYTES):  cfg_rdata = REG_W'(len_q[DIR_RX]);
      A_CTRL:                         cfg_rdata = ctrl_rd;
      REG_AW'(OFS_CUR):               cfg_rdata = REG_W'(remain[DIR_TX]);
      REG_AW'(OFS_CUR + WORD_BYTES):  cfg_rdata = REG_W'(remain[DIR_RX]);
      default:                        cfg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/audma_ring_chk.sv
module audma_ring_chk
  import audma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int REG_AW = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [REG_AW-1:0] cfg_addr,
  input logic [REG_W-1:0]  cfg_wdata,
  input logic [REG_W-1:0]  cfg_rdata,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic [ADDR_W-1:0] rd_req_addr,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [DATA_W-1:0] tx_data,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              tx_half_irq,
  input logic              tx_full_irq,
  input logic              rx_half_irq,
  input logic [NDIR-1:0]   stop_cmd,
  input logic [NDIR-1:0]   reload_q
);
  localparam logic [REG_AW-1:0] A_CTRL = REG_AW'(OFS_CTRL);

  // R3
  stop_bits_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == A_CTRL) |-> (cfg_rdata[CTL_STOP] == 1'b0 &&
                              cfg_rdata[CTL_SPAN+CTL_STOP] == 1'b0));

  // R4
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !stop_cmd[DIR_TX]) |=> (tx_valid && $stable(tx_data)));

  // R4
  rd_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready && !stop_cmd[DIR_TX]) |=>
      (rd_req_valid && $stable(rd_req_addr)));

  // R5
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready && !stop_cmd[DIR_RX]) |=>
      (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  // R7
  tx_half_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_half_irq |=> !tx_half_irq);

  // R7
  rx_half_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_half_irq |=> !rx_half_irq);

  // R8
  tx_full_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_full_irq && !reload_q[DIR_TX]) |-> !rd_req_valid);

  // R10
  tx_force_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == A_CTRL && cfg_wdata[CTL_STOP]) |=> (!rd_req_valid && !tx_valid));
endmodule

bind audma_ring audma_ring_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .REG_AW (REG_AW)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_we       (cfg_we),
  .cfg_addr     (cfg_addr),
  .cfg_wdata    (cfg_wdata),
  .cfg_rdata    (cfg_rdata),
  .rd_req_valid (rd_req_valid),
  .rd_req_ready (rd_req_ready),
  .rd_req_addr  (rd_req_addr),
  .tx_valid     (tx_valid),
  .tx_ready     (tx_ready),
  .tx_data      (tx_data),
  .wr_valid     (wr_valid),
  .wr_ready     (wr_ready),
  .wr_addr      (wr_addr),
  .wr_data      (wr_data),
  .tx_half_irq  (tx_half_irq),
  .tx_full_irq  (tx_full_irq),
  .rx_half_irq  (rx_half_irq),
  .stop_cmd     (stop_cmd),
  .reload_q     (reload_q)
);

// File: tb/audma_ring_tb_top.sv
module audma_ring_tb_top;
  localparam logic [4:0] A_TXB = 5'h00, A_RXB = 5'h04, A_TXL = 5'h08, A_RXL = 5'h0C;
  localparam logic [4:0] A_CTL = 5'h10, A_TXC = 5'h14, A_RXC = 5'h18;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        rd_req_valid, rd_req_ready, rd_rsp_valid, rd_rsp_ready;
  logic [31:0] rd_req_addr, rd_rsp_data;
  logic        tx_valid, tx_ready;
  logic [31:0] tx_data;
  logic        rx_valid = 1'b0, rx_ready;
  logic [31:0] rx_data = '0;
  logic        wr_valid, wr_ready;
  logic [31:0] wr_addr, wr_data;
  logic        tx_half_irq, tx_full_irq, rx_half_irq, rx_full_irq;

  int checks = 0, failures = 0;
  bit done = 0;
  bit rd_stall = 0, tx_stall = 0, wr_stall = 0, tx_hold = 0;
  int tx_limit = 1000;
  int cyc = 0;
  int tx_words = 0, tx_half_n = 0, tx_full_n = 0, tx_half_at = -1, tx_full_at = -1;
  int rx_words = 0, rx_half_n = 0, rx_full_n = 0;
  logic [31:0] txq[$];
  logic [63:0] wrq[$];

  always #5 clk = ~clk;

  audma_ring dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready), .rd_rsp_data(rd_rsp_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .tx_half_irq(tx_half_irq), .tx_full_irq(tx_full_irq),
    .rx_half_irq(rx_half_irq), .rx_full_irq(rx_full_irq)
  );

  function automatic logic [31:0] memf(input logic [31:0] a);
    return {a[15:0] ^ 16'hC3A5, a[15:0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [4:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    cfg_addr = a;
    @(negedge clk);
    d = cfg_rdata;
  endtask

  task automatic clear_counts();
    tx_words = 0; tx_half_n = 0; tx_full_n = 0; tx_half_at = -1; tx_full_at = -1;
    rx_words = 0; rx_half_n = 0; rx_full_n = 0;
  endtask

  task automatic wait_tx(input int n, input string tag);
    int k = 0;
    while (tx_words < n && k < 3000) begin
      @(negedge clk); k++;
    end
    chk(tx_words >= n, tag, tx_words, n);
  endtask

  task automatic send_rx(input logic [31:0] d, input logic [31:0] a);
    wrq.push_back({a, d});
    @(posedge clk); #1;
    rx_valid = 1'b1; rx_data = d;
    do @(negedge clk); while (!(rx_valid && rx_ready));
    @(posedge clk); #1;
    rx_valid = 1'b0;
  endtask

  // memory and sink models, driven just after each rising edge
  initial begin
    logic hs;
    logic [31:0] a;
    rd_req_ready = 1'b1; rd_rsp_valid = 1'b0; rd_rsp_data = '0;
    tx_ready = 1'b1; wr_ready = 1'b1;
    forever begin
      @(negedge clk);
      hs = rd_req_valid && rd_req_ready;
      a  = rd_req_addr;
      @(posedge clk); #1;
      cyc++;
      rd_rsp_valid = hs;
      rd_rsp_data  = memf(a);
      rd_req_ready = rd_stall ? (cyc % 3 != 0) : 1'b1;
      tx_ready     = tx_hold ? 1'b0 : (tx_stall ? (cyc % 4 != 1) : 1'b1);
      wr_ready     = wr_stall ? (cyc % 2 == 0) : 1'b1;
    end
  end

  // transmit monitor: scoreboard pop and interrupt bookkeeping
  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      if (tx_half_irq) begin tx_half_n++; tx_half_at = tx_words; end
      if (tx_full_irq) begin tx_full_n++; tx_full_at = tx_words; end
      if (tx_valid && tx_ready) begin
        if (txq.size() == 0) chk(0, "R4 unexpected transmit word", tx_data, 0);
        else begin
          logic [31:0] e;
          e = txq.pop_front();
          chk(tx_data == e, "R4 transmit word", tx_data, e);
        end
        tx_words++;
        if (tx_words == tx_limit) tx_hold = 1;
      end
    end
  end

  // memory write monitor
  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      if (rx_half_irq) rx_half_n++;
      if (rx_full_irq) rx_full_n++;
      if (wr_valid && wr_ready) begin
        if (wrq.size() == 0) chk(0, "R5 unexpected write", {wr_addr, wr_data}, 0);
        else begin
          logic [63:0] e;
          e = wrq.pop_front();
          chk({wr_addr, wr_data} == e, "R5 write addr/data", {wr_addr, wr_data}, e);
        end
        rx_words++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int bad;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk(!rd_req_valid && !tx_valid && !rx_ready && !wr_valid && !rd_rsp_ready,
        "R1 handshakes idle", {rd_req_valid, tx_valid, rx_ready, wr_valid}, 0);
    chk(!tx_half_irq && !tx_full_irq && !rx_half_irq && !rx_full_irq, "R1 irqs low",
        {tx_half_irq, tx_full_irq, rx_half_irq, rx_full_irq}, 0);
    bad = 0;
    for (int i = 0; i < 7; i++) begin
      rd_reg(5'(i * 4), v);
      if (v != 0) bad++;
    end
    chk(bad == 0, "R1 registers zero", bad, 0);

    // R2 register masking
    wr_reg(A_TXB, 32'h1000_0003);
    rd_reg(A_TXB, v); chk(v == 32'h1000_0000, "R2 tx base", v, 32'h1000_0000);
    wr_reg(A_TXL, 32'hFFFF_FFFF);
    rd_reg(A_TXL, v); chk(v == 32'h03FF_FFFC, "R2 tx length mask", v, 32'h03FF_FFFC);
    wr_reg(A_RXB, 32'h2000_0002);
    rd_reg(A_RXB, v); chk(v == 32'h2000_0000, "R2 rx base", v, 32'h2000_0000);

    // R3 control readback with stop bits written high while idle
    wr_reg(A_CTL, 32'h0106_0206);
    rd_reg(A_CTL, v); chk(v == 32'h0104_0204, "R3 control readback", v, 32'h0104_0204);

    // R4 R6 R7 R8 one-shot playback with back-pressure, 32 bytes
    clear_counts();
    rd_stall = 1; tx_stall = 1;
    for (int k = 0; k < 8; k++) txq.push_back(memf(32'h1000 + 4 * k));
    wr_reg(A_TXB, 32'h1000);
    wr_reg(A_TXL, 32);
    wr_reg(A_CTL, 32'h0000_0201);
    wait_tx(8, "R4 eight words delivered");
    repeat (20) @(negedge clk);
    chk(tx_words == 8, "R8 no words after full", tx_words, 8);
    chk(tx_half_n == 1 && tx_half_at == 4, "R7 half after word 4", tx_half_at, 4);
    chk(tx_full_n == 1 && tx_full_at == 8, "R8 full after word 8", tx_full_at, 8);
    rd_reg(A_CTL, v); chk(v[0] == 1'b0, "R8 enable cleared", v, 0);
    rd_reg(A_TXC, v); chk(v == 0, "R6 count at zero", v, 0);
    chk(txq.size() == 0, "R4 scoreboard drained", txq.size(), 0);
    rd_stall = 0; tx_stall = 0;

    // R7 R8 minimum 8-byte transfer
    clear_counts();
    for (int k = 0; k < 2; k++) txq.push_back(memf(32'h3000 + 4 * k));
    wr_reg(A_TXB, 32'h3000);
    wr_reg(A_TXL, 8);
    wr_reg(A_CTL, 32'h0000_0001);
    wait_tx(2, "R4 minimum transfer words");
    repeat (10) @(negedge clk);
    chk(tx_half_at == 1 && tx_half_n == 1, "R7 half on first word of 8 bytes", tx_half_at, 1);
    chk(tx_full_at == 2 && tx_words == 2, "R8 full on second word", tx_full_at, 2);

    // R9 R10 R11 R6 both directions with reload
    clear_counts();
    wr_stall = 1;
    for (int k = 0; k < 10; k++) txq.push_back(memf(32'h4000 + 4 * (k % 4)));
    tx_limit = 10;
    wr_reg(A_TXB, 32'h4000); wr_reg(A_TXL, 16);
    wr_reg(A_RXB, 32'h8000); wr_reg(A_RXL, 16);
    wr_reg(A_CTL, 32'h0005_0005);
    send_rx(32'hA000_0001, 32'h8000);
    send_rx(32'hA000_0002, 32'h8004);
    send_rx(32'hA000_0003, 32'h8008);
    wait_tx(10, "R9 ten words across wrap");
    repeat (10) @(negedge clk);
    chk(tx_words == 10, "R9 held at ten words", tx_words, 10);
    chk(tx_full_n == 2 && tx_half_n == 3, "R9 irq counts after two wraps",
        {tx_full_n[31:0], tx_half_n[31:0]}, {32'd2, 32'd3});
    rd_reg(A_TXC, v); chk(v == 8, "R6 R9 playback count after ten words", v, 8);
    rd_reg(A_RXC, v); chk(v == 4, "R6 record count after three words", v, 4);
    wr_reg(A_CTL, 32'h0005_0006);
    rd_reg(A_CTL, v);
    chk(v[0] == 1'b0, "R10 playback enable cleared", v, 32'h0005_0004);
    chk(v[16] == 1'b1, "R11 record still enabled", v, 32'h0005_0004);
    rd_reg(A_TXC, v); chk(v == 8, "R10 count held after stop", v, 8);
    rd_reg(A_RXC, v); chk(v == 4, "R11 record count untouched", v, 4);
    tx_hold = 0; tx_limit = 1000;
    bad = 0;
    repeat (12) begin
      @(negedge clk);
      if (rd_req_valid || tx_valid) bad++;
    end
    chk(bad == 0, "R10 no playback traffic after stop", bad, 0);
    send_rx(32'hA000_0004, 32'h800C);
    send_rx(32'hA000_0005, 32'h8000);
    repeat (6) @(negedge clk);
    chk(rx_words == 5 && rx_full_n == 1 && rx_half_n == 1, "R9 record wrap irqs",
        {rx_words[15:0], rx_full_n[15:0], rx_half_n[15:0]}, {16'd5, 16'd1, 16'd1});
    rd_reg(A_RXC, v); chk(v == 12, "R9 record count reloaded", v, 12);
    chk(wrq.size() == 0, "R5 write scoreboard drained", wrq.size(), 0);
    wr_stall = 0;

    // R12 enable written while running does not restart
    clear_counts();
    for (int k = 0; k < 8; k++) txq.push_back(memf(32'h5000 + 4 * k));
    tx_limit = 3;
    wr_reg(A_TXB, 32'h5000); wr_reg(A_TXL, 32);
    wr_reg(A_CTL, 32'h0000_0001);
    wait_tx(3, "R12 three words");
    repeat (8) @(negedge clk);
    rd_reg(A_TXC, v); chk(v == 20, "R12 count before re-enable", v, 20);
    wr_reg(A_CTL, 32'h0000_0001);
    rd_reg(A_TXC, v); chk(v == 20, "R12 count not reloaded", v, 20);
    rd_reg(A_CTL, v); chk(v[0] == 1'b1, "R12 still enabled", v, 1);
    tx_limit = 1000; tx_hold = 0;
    wait_tx(8, "R12 finishes original eight words");
    repeat (20) @(negedge clk);
    chk(tx_words == 8 && tx_full_n == 1, "R12 no restart", tx_words, 8);

    finish_run();
  end
endmodule